// File: doc/BRIEF.md
# Packed Register-Write Command Decoder

This block sits behind a command-fetch engine and turns a stream of 32-bit words into single register writes. The words come in packets of five. The first word of a packet holds four compressed 8-bit register indices. The four words after it are the values to write. Each index has a bank bit and a 7-bit offset. The block expands the bank bit and offset into a full byte address inside one of two register windows that lie far apart. It then issues the four writes in header order, one per cycle. One index value names a padding register. A packet uses that index to fill a slot it does not need, and a slot holding it produces no write strobe.

The input is a valid/ready word stream, and back-pressure works as follows. A word moves only on a cycle where `s_valid` and `s_ready` are both high. The producer may drop `s_valid` between any two words without losing progress. `s_ready` goes low for exactly the four cycles that follow the acceptance of a packet's last word, while the decoded writes go out. The write port has no handshake: the register file takes each strobe in the cycle it appears.

Top module: `regpack_decoder`

## Requirements
- R1: A packet is five accepted words: one header, then four data words. No write strobe appears before the fifth word of a packet is accepted.
- R2: Header bits [8k+7:8k] are the index for data word k+1 (k = 0..3). The writes for slots 0, 1, 2 and 3 appear in that order, in the four consecutive cycles that follow the acceptance of the fifth word. Each write carries its own data word.
- R3: An index with bit 7 = 0 selects the low bank, and its byte address is 0x1C00 + 4 × index[6:0].
- R4: An index with bit 7 = 1 selects the high bank, and its byte address is 0x2C00 + 4 × index[6:0].
- R5: Index 0x15 (address 0x1C54) is padding. Its slot raises no write strobe but still takes up its issue cycle. Index 0x95 is an ordinary high-bank register.
- R6: `s_ready` is low during the four issue cycles and high at all other times outside reset.
- R7: `idle` is high only when no packet is partly received and no write is pending.
- R8: A synchronous reset discards any partial packet and any pending writes. After reset the next accepted word is treated as a header.
- R9: Gaps in `s_valid` between words of a packet do not change the decoded writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Block can take a word |
| s_data | input | 32 | Stream word (header or data) |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register write value |
| idle | output | 1 | No partial packet and no pending write |

## Verification
If the word counter holds the wrong value, every later header is taken as data. The wrong addresses then reach `wr_addr` in the very next issue window, and stay wrong for every later packet. If the slot sequencer slips, data lands on the wrong address, or `s_ready` comes back after some number of cycles other than four, and this shows within the same packet. Reset has to clear state: a missed clear shows as a shifted decode of the first packet sent after the reset.

// File: rtl/regpack_pkg.sv
package regpack_pkg;
  typedef enum logic {PH_GATHER, PH_ISSUE} phase_e;
endpackage

// File: rtl/regpack_gather.sv
module regpack_gather #(
  parameter int IDX_W = 8,
  parameter int SLOTS = 4,
  localparam int WORD_W = IDX_W * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hold,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [WORD_W-1:0]            s_data,
  output logic                         pkt_done,
  output logic                         partial,
  output logic [WORD_W-1:0]            header,
  output logic [SLOTS-1:0][WORD_W-1:0] payload
);
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign s_ready  = ~hold;
  assign take     = s_valid & s_ready;
  assign pkt_done = take && (cnt == CNT_W'(SLOTS));
  assign partial  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (take) begin
      if (cnt == CNT_W'(SLOTS)) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && cnt == '0) header <= s_data;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (take && cnt == CNT_W'(g + 1)) payload[g] <= s_data;
    end
  end
endmodule

// File: rtl/regpack_idx_map.sv
module regpack_idx_map #(
  parameter int IDX_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 'h2C00,
  parameter logic [IDX_W-1:0]  PAD_IDX = 'h15
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              is_pad
);
  logic [ADDR_W-1:0] offs;

  assign offs   = ADDR_W'({idx[IDX_W-2:0], 2'b00});
  assign addr   = (idx[IDX_W-1] ? BANK1_BASE : BANK0_BASE) + offs;
  assign is_pad = (idx == PAD_IDX);
endmodule

// File: rtl/regpack_issue.sv
module regpack_issue
  import regpack_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [SLOTS-1:0][ADDR_W-1:0] addrs,
  input  logic [SLOTS-1:0]             pads,
  input  logic [SLOTS-1:0][WORD_W-1:0] vals,
  output logic                         busy,
  output logic                         wr_en,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [WORD_W-1:0]            wr_data
);
  phase_e            phase;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_GATHER;
      slot  <= '0;
    end else if (start) begin
      phase <= PH_ISSUE;
      slot  <= '0;
    end else if (phase == PH_ISSUE) begin
      if (slot == SLOT_W'(SLOTS - 1)) begin
        phase <= PH_GATHER;
        slot  <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign busy    = (phase == PH_ISSUE);
  assign wr_en   = busy && !pads[slot];
  assign wr_addr = addrs[slot];
  assign wr_data = vals[slot];
endmodule

// File: rtl/regpack_decoder.sv
module regpack_decoder #(
  parameter int IDX_W = 8,
  parameter int SLOTS = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 'h2C00,
  parameter logic [IDX_W-1:0]  PAD_IDX = 'h15,
  localparam int WORD_W = IDX_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              idle
);
  logic                         busy, pkt_done, partial;
  logic [WORD_W-1:0]            header;
  logic [SLOTS-1:0][WORD_W-1:0] payload;
  logic [SLOTS-1:0][ADDR_W-1:0] addrs;
  logic [SLOTS-1:0]             pads;

  regpack_gather #(.IDX_W(IDX_W), .SLOTS(SLOTS)) gather_i (
    .clk(clk), .rst(rst), .hold(busy),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .pkt_done(pkt_done), .partial(partial),
    .header(header), .payload(payload)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_map
    regpack_idx_map #(
      .IDX_W(IDX_W), .ADDR_W(ADDR_W),
      .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE), .PAD_IDX(PAD_IDX)
    ) map_i (
      .idx(header[k*IDX_W +: IDX_W]),
      .addr(addrs[k]),
      .is_pad(pads[k])
    );
  end

  regpack_issue #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) issue_i (
    .clk(clk), .rst(rst), .start(pkt_done),
    .addrs(addrs), .pads(pads), .vals(payload),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign idle = ~busy & ~partial;
endmodule

// File: rtl/regpack_decoder_chk.sv
module regpack_decoder_chk #(
  parameter int IDX_W = 8,
  parameter int SLOTS = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 'h2C00,
  parameter logic [IDX_W-1:0]  PAD_IDX = 'h15,
  localparam int SPAN = 4 * (2 ** (IDX_W - 1)),
  localparam logic [ADDR_W-1:0] PAD_ADDR =
    (PAD_IDX[IDX_W-1] ? BANK1_BASE : BANK0_BASE) + ADDR_W'({PAD_IDX[IDX_W-2:0], 2'b00})
) (
  input logic              clk,
  input logic              rst,
  input logic              s_ready,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              idle
);
  logic [7:0] stall_cnt;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)           stall_cnt <= '0;
    else if (!s_ready) stall_cnt <= stall_cnt + 1'b1;
    else               stall_cnt <= '0;
  end

  AST_WRITE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !s_ready); // R6
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
    stall_cnt <= 8'(SLOTS)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!wr_en && s_ready)); // R7
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_addr >= BANK0_BASE && wr_addr < BANK0_BASE + ADDR_W'(SPAN)) ||
               (wr_addr >= BANK1_BASE && wr_addr < BANK1_BASE + ADDR_W'(SPAN)))); // R3 R4
  AST_NO_PAD_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != PAD_ADDR)); // R5

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEARS: assert (idle && s_ready && !wr_en); // R8
    end
  end
endmodule

bind regpack_decoder regpack_decoder_chk #(
  .IDX_W(IDX_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
  .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE), .PAD_IDX(PAD_IDX)
) chk_i (
  .clk(clk), .rst(rst), .s_ready(s_ready),
  .wr_en(wr_en), .wr_addr(wr_addr), .idle(idle)
);

// File: tb/regpack_decoder_tb_top.sv
`timescale 1ns/1ps
module regpack_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        idle;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  regpack_decoder dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_addr(input int idx);
    if (idx >= 128) return 16'(11264 + 4 * (idx - 128));
    return 16'(7168 + 4 * idx);
  endfunction

  task automatic push(input logic [31:0] w, input int gap);
    @(posedge clk); #1;
    for (int i = 0; i < gap; i++) begin
      @(posedge clk); #1;
    end
    s_valid = 1'b1;
    s_data  = w;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 1'b0;
    s_data  = 32'hDEAD_BEEF;
  endtask

  task automatic pulse_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(idle && s_ready && !wr_en, "R8 reset state", {29'd0, idle, s_ready, wr_en}, 32'h6);
  endtask

  task automatic run_packet(input logic [31:0] hdr, input logic [31:0] d[4], input int gap);
    push(hdr, gap);
    @(negedge clk);
    check(!idle && !wr_en, "R7 partial not idle", {30'd0, idle, wr_en}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      push(d[k], gap);
      @(negedge clk);
      check(!wr_en, "R1 no write before fifth word", {31'd0, wr_en}, 32'h0);
    end
    push(d[3], gap);
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = int'(hdr[8*k +: 8]);
      @(negedge clk);
      check(!s_ready, "R6 ready low while issuing", {31'd0, s_ready}, 32'h0);
      if (idx == 8'h15) begin
        check(!wr_en, "R5 pad slot silent", {31'd0, wr_en}, 32'h0);
      end else begin
        check(wr_en, "R2 strobe in slot", {31'd0, wr_en}, 32'h1);
        if (idx >= 128)
          check(wr_addr == exp_addr(idx), "R4 high bank address", {16'd0, wr_addr}, {16'd0, exp_addr(idx)});
        else
          check(wr_addr == exp_addr(idx), "R3 low bank address", {16'd0, wr_addr}, {16'd0, exp_addr(idx)});
        check(wr_data == d[k], "R2 data order", wr_data, d[k]);
      end
    end
    @(negedge clk);
    check(s_ready && idle && !wr_en, "R6 R7 back to ready", {29'd0, s_ready, idle, wr_en}, 32'h6);
  endtask

  initial begin
    logic [31:0] d[4];
    logic [31:0] hdr;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(idle && s_ready && !wr_en, "R8 initial reset state", {29'd0, idle, s_ready, wr_en}, 32'h6);

    // sweep: every index value appears once, rotating through slots; R9 gaps vary
    for (int p = 0; p < 64; p++) begin
      hdr = '0;
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = ((p * 4 + k) * 37) % 256;
        hdr[8*k +: 8] = 8'(idx);
        d[k] = 32'(p * 65536 + k * 4096 + idx) ^ 32'hC3A5_0000;
      end
      run_packet(hdr, d, p % 3);
    end

    // R5: an all-pad packet still takes four issue cycles
    for (int k = 0; k < 4; k++) d[k] = 32'h1111_1111 * (k + 1);
    run_packet(32'h1515_1515, d, 0);
    // R5 R4: pad index only in the low bank; 0x95 is an ordinary write
    run_packet(32'h9515_0095, d, 1);

    // R8: reset mid-packet discards the partial words
    push(32'h8081_8283, 0);
    push(32'hAAAA_AAAA, 0);
    push(32'hBBBB_BBBB, 2);
    pulse_reset();
    for (int k = 0; k < 4; k++) d[k] = 32'h7000_0000 + 32'(k);
    run_packet(32'h7F00_FF80, d, 0);

    // R8: reset during issue cancels the remaining writes
    push(32'h0102_0304, 0);
    for (int k = 0; k < 4; k++) push(32'h5000_0000 + 32'(k), 0);
    @(negedge clk);
    check(wr_en, "R2 first slot before reset", {31'd0, wr_en}, 32'h1);
    pulse_reset();
    @(negedge clk);
    check(!wr_en && idle, "R8 no writes after reset", {30'd0, wr_en, idle}, 32'h1);
    run_packet(32'h0403_0201, d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule